// File: doc/BRIEF.md
# SMBus Byte-Addressed Memory Target

This block is a bus target for a two-wire SMBus/I2C segment. It holds a 256-byte memory and an 8-bit current-position pointer. It watches SCL and SDA as plain inputs and oversamples them with the system clock. It pulls SDA low through an open-drain enable output and never drives SDA high. The target answers one 7-bit bus address. That address is a base value plus an instance index, so several copies on one segment can sit at consecutive addresses.

The target handles five transaction shapes. A quick command is the address alone. A send byte moves the pointer. A receive byte reads at the pointer and advances it. A write with a command byte treats the command byte as the start offset. A read with a command byte has the form: write address, command byte, repeated START, read address. Multi-byte transfers carry no length byte, and offsets wrap from 255 to 0. A parallel load port lets the surrounding logic fill the memory without using the bus.

Top module: `smbus_mem_target`

## Requirements
- R1: After reset the pointer is 0 and SDA is released (`sda_oe_o` = 0).
- R2: The target acknowledges only the address BASE_ADDR + INST_IDX, by pulling SDA low in the ninth clock. After an address mismatch, SDA stays released until the next START or STOP, and neither the memory nor the pointer changes.
- R3: A write-direction transaction that carries exactly one byte and ends in STOP loads that byte into the pointer and writes no memory.
- R4: A read-direction transaction returns the byte at the pointer, MSB first. The pointer advances by one at the controller's acknowledge bit for each byte sent, wrapping from 255 to 0.
- R5: In a write-direction transaction, the first byte after the address is the start offset. Each later byte is stored at the next location, with no length byte, and location 255 is followed by location 0.
- R6: A write transaction that stores data leaves the pointer unchanged.
- R7: Write address, command byte, repeated START, read address: the first byte returned comes from the command offset and the later bytes from the following locations.
- R8: A quick command (address, then STOP) is acknowledged and changes neither memory nor pointer.
- R9: When the controller NACKs a read byte, the target stops driving SDA until the next START or STOP.
- R10: The target asserts its SDA pull-down only while SCL is low.
- R11: When `load_en_i` is high, the load port writes `load_data_i` to `load_addr_i` in that cycle, and this write takes priority over a bus write.
- R12: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. A repeated START with no byte in between restarts address decoding and keeps the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Sampled bus clock line |
| sda_i | input | 1 | Sampled bus data line |
| sda_oe_o | output | 1 | 1 = pull SDA low; 0 = release |
| load_en_i | input | 1 | Parallel load strobe |
| load_addr_i | input | ADDR_W | Parallel load location |
| load_data_i | input | 8 | Parallel load byte |

## Verification
Some properties are checked on every cycle by assertions. The SDA pull-down must never begin while SCL is high. The pointer may change only by a single increment or at a START/STOP boundary. The pointer must hold steady across every bus memory write. SDA must be released right after a START.

Other behaviour only the bench scenarios can show. This covers the transaction semantics: send byte versus command write, the offset wrap on writes and on reads, the repeated-START command read, and address filtering against a second address. It also covers memory contents read back through the bus after loads and writes.

// File: rtl/smbus_tgt_pkg.sv
package smbus_tgt_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_IGNORE
  } tgt_state_e;
endpackage

// File: rtl/smbus_tgt_sync.sv
module smbus_tgt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES:0] scl_sh, sda_sh;
  logic scl_p, sda_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= {scl_sh[STAGES-1:0], scl_i};
      sda_sh <= {sda_sh[STAGES-1:0], sda_i};
    end
  end

  assign scl_o = scl_sh[STAGES-1];
  assign sda_o = sda_sh[STAGES-1];
  assign scl_p = scl_sh[STAGES];
  assign sda_p = sda_sh[STAGES];

  assign scl_rise_o = scl_o & ~scl_p;
  assign scl_fall_o = ~scl_o & scl_p;
  // data edges while clock stays high
  assign start_o = scl_o & scl_p & sda_p & ~sda_o;
  assign stop_o  = scl_o & scl_p & ~sda_p & sda_o;
endmodule

// File: rtl/smbus_tgt_mem.sv
module smbus_tgt_mem #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          load_en_i,
  input  logic [AW-1:0] load_addr_i,
  input  logic [DW-1:0] load_data_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (load_en_i)    mem_q[load_addr_i] <= load_data_i;
    else if (wr_en_i) mem_q[wr_addr_i]   <= wr_data_i;
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/smbus_tgt_fsm.sv
module smbus_tgt_fsm
  import smbus_tgt_pkg::*;
#(
  parameter int          AW       = 8,
  parameter logic [6:0]  DEV_ADDR = 7'h50
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic [AW-1:0]     rd_addr_o,
  output logic              wr_en_o,
  output logic [AW-1:0]     wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              sda_oe_o,
  output logic [AW-1:0]     ptr_o
);
  localparam logic [AW-1:0] PTR_ONE = AW'(1);
  localparam logic [3:0]    LAST_BIT = 4'd8;

  tgt_state_e        state_q;
  logic [3:0]        bit_cnt_q;
  logic [BYTE_W-1:0] shreg_q, cmd_q;
  logic [AW-1:0]     ptr_q, wr_idx_q;
  logic              rw_q, cmd_seen_q, data_seen_q, nack_q;
  logic              byte_done;

  assign byte_done = scl_fall_i && (bit_cnt_q == LAST_BIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      bit_cnt_q   <= '0;
      shreg_q     <= '0;
      cmd_q       <= '0;
      ptr_q       <= '0;
      wr_idx_q    <= '0;
      rw_q        <= 1'b0;
      cmd_seen_q  <= 1'b0;
      data_seen_q <= 1'b0;
      nack_q      <= 1'b0;
    end else if (start_i || stop_i) begin
      // lone command byte: send-byte or setup for a command read
      if (cmd_seen_q && !data_seen_q) ptr_q <= cmd_q[AW-1:0];
      cmd_seen_q  <= 1'b0;
      data_seen_q <= 1'b0;
      bit_cnt_q   <= '0;
      state_q     <= start_i ? ST_ADDR : ST_IDLE;
    end else begin
      unique case (state_q)
        ST_ADDR: begin
          if (scl_rise_i) begin
            shreg_q   <= {shreg_q[BYTE_W-2:0], sda_i};
            bit_cnt_q <= bit_cnt_q + 4'd1;
          end else if (byte_done) begin
            bit_cnt_q <= '0;
            if (shreg_q[7:1] == DEV_ADDR) begin
              rw_q    <= shreg_q[0];
              state_q <= ST_ADDR_ACK;
            end else begin
              state_q <= ST_IGNORE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall_i) begin
            if (rw_q) begin
              shreg_q <= rd_data_i;
              state_q <= ST_TX;
            end else begin
              state_q <= ST_RX;
            end
          end
        end
        ST_RX: begin
          if (scl_rise_i) begin
            shreg_q   <= {shreg_q[BYTE_W-2:0], sda_i};
            bit_cnt_q <= bit_cnt_q + 4'd1;
          end else if (byte_done) begin
            bit_cnt_q <= '0;
            state_q   <= ST_RX_ACK;
            if (!cmd_seen_q) begin
              cmd_q      <= shreg_q;
              cmd_seen_q <= 1'b1;
              wr_idx_q   <= shreg_q[AW-1:0];
            end else begin
              data_seen_q <= 1'b1;
              wr_idx_q    <= wr_idx_q + PTR_ONE;
            end
          end
        end
        ST_RX_ACK: begin
          if (scl_fall_i) state_q <= ST_RX;
        end
        ST_TX: begin
          if (scl_rise_i) begin
            bit_cnt_q <= bit_cnt_q + 4'd1;
          end else if (byte_done) begin
            bit_cnt_q <= '0;
            state_q   <= ST_TX_ACK;
          end else if (scl_fall_i) begin
            shreg_q <= {shreg_q[BYTE_W-2:0], 1'b0};
          end
        end
        ST_TX_ACK: begin
          if (scl_rise_i) begin
            ptr_q  <= ptr_q + PTR_ONE;
            nack_q <= sda_i;
          end else if (scl_fall_i) begin
            if (nack_q) begin
              state_q <= ST_IGNORE;
            end else begin
              shreg_q <= rd_data_i;
              state_q <= ST_TX;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (state_q)
      ST_ADDR_ACK, ST_RX_ACK: sda_oe_o = 1'b1;
      ST_TX:                  sda_oe_o = ~shreg_q[BYTE_W-1];
      default:                sda_oe_o = 1'b0;
    endcase
  end

  assign wr_en_o   = (state_q == ST_RX) && byte_done && cmd_seen_q && !start_i && !stop_i;
  assign wr_addr_o = wr_idx_q;
  assign wr_data_o = shreg_q;
  assign rd_addr_o = ptr_q;
  assign ptr_o     = ptr_q;
endmodule

// File: rtl/smbus_mem_target.sv
module smbus_mem_target
  import smbus_tgt_pkg::*;
#(
  parameter int          ADDR_W      = 8,
  parameter logic [6:0]  BASE_ADDR   = 7'h50,
  parameter int unsigned INST_IDX    = 0,
  parameter int          SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic              load_en_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic [BYTE_W-1:0] load_data_i
);
  localparam logic [6:0] DEV_ADDR = 7'(BASE_ADDR + INST_IDX);

  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic bus_we;
  logic [ADDR_W-1:0] rd_addr, wr_addr, ptr;
  logic [BYTE_W-1:0] rd_data, wr_data;

  smbus_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_evt),
    .stop_o     (stop_evt)
  );

  smbus_tgt_fsm #(.AW(ADDR_W), .DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sda_i      (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_evt),
    .stop_i     (stop_evt),
    .rd_data_i  (rd_data),
    .rd_addr_o  (rd_addr),
    .wr_en_o    (bus_we),
    .wr_addr_o  (wr_addr),
    .wr_data_o  (wr_data),
    .sda_oe_o   (sda_oe_o),
    .ptr_o      (ptr)
  );

  smbus_tgt_mem #(.AW(ADDR_W), .DW(BYTE_W)) u_mem (
    .clk_i       (clk_i),
    .load_en_i   (load_en_i),
    .load_addr_i (load_addr_i),
    .load_data_i (load_data_i),
    .wr_en_i     (bus_we),
    .wr_addr_i   (wr_addr),
    .wr_data_i   (wr_data),
    .rd_addr_i   (rd_addr),
    .rd_data_o   (rd_data)
  );
endmodule

// File: rtl/smbus_mem_target_chk.sv
module smbus_mem_target_chk #(
  parameter int AW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          scl_s,
  input logic          sda_oe_o,
  input logic          start_evt,
  input logic          stop_evt,
  input logic          bus_we,
  input logic [AW-1:0] ptr
);
  // R10
  a_r10_pull_only_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_s);

  // R6
  a_r6_write_keeps_ptr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_we |=> (ptr == $past(ptr)));

  // R4
  a_r4_ptr_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr != $past(ptr)) |-> ((ptr == $past(ptr) + AW'(1)) || $past(start_evt || stop_evt)));

  // R12
  a_r12_start_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_evt |=> !sda_oe_o);
endmodule

bind smbus_mem_target smbus_mem_target_chk #(.AW(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .scl_s     (scl_s),
  .sda_oe_o  (sda_oe_o),
  .start_evt (start_evt),
  .stop_evt  (stop_evt),
  .bus_we    (bus_we),
  .ptr       (ptr)
);

// File: tb/smbus_mem_target_test.sv
module smbus_mem_target_test;
  localparam int Q = 5;
  localparam logic [6:0] DEV   = 7'h52;
  localparam logic [6:0] OTHER = 7'h50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic scl = 1'b1, sda_m = 1'b1;
  logic sda_oe, sda_bus;
  logic ld_en = 1'b0;
  logic [7:0] ld_addr = '0, ld_data = '0;
  assign sda_bus = sda_m & ~sda_oe;

  int errs = 0, checks = 0;
  int quiet_viol = 0, r10_viol = 0;
  logic quiet = 1'b0, done = 1'b0, oe_d = 1'b0;
  logic [7:0] ref_mem [256];
  logic [7:0] ref_ptr = '0;

  smbus_mem_target #(.INST_IDX(2)) uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .load_en_i(ld_en), .load_addr_i(ld_addr), .load_data_i(ld_data)
  );

  always @(posedge clk) begin
    if (quiet && sda_oe) quiet_viol++;
    if (rst_n && sda_oe && !oe_d && scl) r10_viol++;
    oe_d <= sda_oe;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hold(); scl = 1'b1; hold(); sda_m = 1'b0; hold(); scl = 1'b0; hold();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hold(); scl = 1'b1; hold(); sda_m = 1'b1; hold();
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; hold(); scl = 1'b1; hold(); scl = 1'b0; hold();
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; hold(); scl = 1'b1; hold(); b = sda_bus; scl = 1'b0; hold();
  endtask

  task automatic wr_byte(input logic [7:0] d, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(a);
    ack = !a;
  endtask

  task automatic rd_byte(input logic last, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); d[i] = b; end
    put_bit(last);
  endtask

  task automatic send_byte(input logic [7:0] v);
    logic ack;
    bus_start(); wr_byte({DEV, 1'b0}, ack); chk("R3 addr ack", ack, 1);
    wr_byte(v, ack); chk("R3 byte ack", ack, 1); bus_stop();
    ref_ptr = v;
  endtask

  task automatic recv_byte(input string req);
    logic ack; logic [7:0] d;
    bus_start(); wr_byte({DEV, 1'b1}, ack); rd_byte(1'b1, d); bus_stop();
    chk(req, d, ref_mem[ref_ptr]);
    ref_ptr = ref_ptr + 8'd1;
  endtask

  task automatic write_blk(input logic [7:0] off, input int n);
    logic ack; logic [7:0] a, v;
    bus_start(); wr_byte({DEV, 1'b0}, ack); wr_byte(off, ack);
    for (int k = 0; k < n; k++) begin
      a = off + 8'(k);
      v = 8'(off * 3 + k * 53) ^ 8'hA5;
      wr_byte(v, ack); chk("R5 data ack", ack, 1);
      ref_mem[a] = v;
    end
    bus_stop();
  endtask

  task automatic read_blk(input logic [7:0] off, input int n);
    logic ack; logic [7:0] d, a;
    bus_start(); wr_byte({DEV, 1'b0}, ack); wr_byte(off, ack);
    bus_start(); wr_byte({DEV, 1'b1}, ack); chk("R7 read addr ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      a = off + 8'(k);
      rd_byte(k == n - 1, d);
      chk("R7 read data", d, ref_mem[a]);
    end
    bus_stop();
    ref_ptr = off + 8'(n);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic ack; logic [7:0] d;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    hold();
    chk("R1 sda released", sda_oe, 0);

    // R11 preload through parallel port
    for (int i = 0; i < 256; i++) begin
      ld_en = 1'b1; ld_addr = 8'(i); ld_data = 8'(i * 29 + 7);
      ref_mem[i] = 8'(i * 29 + 7);
      @(negedge clk);
    end
    ld_en = 1'b0;
    recv_byte("R1 R11 first read at pointer 0");
    recv_byte("R4 pointer increment");

    // R2 other address: no ack, no drive, no effect
    bus_start(); quiet = 1'b1;
    wr_byte({OTHER, 1'b0}, ack);
    wr_byte(8'h10, ack); wr_byte(8'h99, ack);
    quiet = 1'b0; bus_stop();
    chk("R2 mismatch not acked", ack, 0);
    chk("R2 sda quiet on mismatch", quiet_viol, 0);
    recv_byte("R2 pointer kept");

    // R3 send byte then R4 wrap
    send_byte(8'hFE);
    recv_byte("R4 read at FE");
    recv_byte("R4 read at FF");
    recv_byte("R4 wrap to 00");

    // R5 wrapping write, R6 pointer untouched
    write_blk(8'hFD, 5);
    recv_byte("R6 pointer unchanged by write");
    read_blk(8'hFD, 5);
    read_blk(8'h10, 2); // R2 R3 memory untouched

    // R8 quick command
    bus_start(); wr_byte({DEV, 1'b0}, ack); bus_stop();
    chk("R8 quick acked", ack, 1);
    recv_byte("R8 quick no effect");

    // R12 repeated START with no command byte keeps pointer
    send_byte(8'h40);
    bus_start(); wr_byte({DEV, 1'b0}, ack);
    bus_start(); wr_byte({DEV, 1'b1}, ack); rd_byte(1'b1, d);
    chk("R12 restart keeps pointer", d, ref_mem[8'h40]);
    ref_ptr = 8'h41;
    // R9 released after NACK
    hold();
    chk("R9 released after nack", sda_oe, 0);
    bus_stop();

    // R9 multi-byte receive with ACKs then NACK
    bus_start(); wr_byte({DEV, 1'b1}, ack);
    for (int k = 0; k < 3; k++) begin
      rd_byte(k == 2, d);
      chk("R9 R4 streamed read", d, ref_mem[ref_ptr]);
      ref_ptr = ref_ptr + 8'd1;
    end
    quiet = 1'b1; hold(); hold(); quiet = 1'b0;
    bus_stop();
    chk("R9 no drive after nack", quiet_viol, 0);
    recv_byte("R4 pointer after stream");

    // sweep of offsets
    for (int i = 0; i < 16; i++) begin
      write_blk(8'(i * 17 + 3), 3);
      read_blk(8'(i * 17 + 3), 3);
    end
    recv_byte("R7 pointer after command read");

    chk("R10 pull-down only while SCL low", r10_viol, 0);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule